// File: doc/BRIEF.md
# Clock Synthesizer Reprogramming Sequencer

This block is a control state machine that reprograms an on-chip clock synthesizer whenever the video standard changes between standard definition (27 MHz input) and high definition (74.25 MHz input). It watches a mode input, picks which of two stored parameter images the scan-chain reconfiguration engine should read, and then runs a two-phase command sequence against that engine. The first phase is a load-from-memory strobe, and the second is an apply strobe. Each strobe is followed by a wait on the engine's busy flag. The sequencer finishes by waiting for the synthesizer to report lock again, and it signals either a one-cycle done pulse or a sticky error flag.

The sequencer is meant to run on a free-running housekeeping clock that is never an output of the synthesizer being reprogrammed. That clock also clocks the engine's scan logic, so its frequency must stay at or below what the engine's scan interface allows. The mode input may come from another clock domain and is brought in through a two-flop synchronizer.

States: `ST_IDLE` waits for the synchronized mode to differ from the programmed image. It goes to `ST_LOAD`, which issues the load strobe. `ST_LD_WAIT_HI` waits for busy to rise and moves to `ST_LD_WAIT_LO`. `ST_LD_WAIT_LO` waits for busy to fall and moves to `ST_SETTLE`. `ST_SETTLE` counts the settle delay and moves to `ST_APPLY`, which issues the apply strobe. `ST_AP_WAIT_HI` waits for busy to rise and moves to `ST_AP_WAIT_LO`. `ST_AP_WAIT_LO` waits for busy to fall and moves to `ST_LOCK_WAIT`. `ST_LOCK_WAIT` has two exits. If lock is seen it goes to `ST_DONE`. If the timeout expires it sets the error flag and returns to `ST_IDLE`. `ST_DONE` returns to `ST_IDLE`.

Top module: `clk_reprog_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after a reset edge, `load_pulse`, `apply_pulse`, `seq_done` and `seq_err` are 0 and `img_sel` is 0. Reset abandons any sequence in progress.
- R2: A change on `mode_in` starts a sequence. `load_pulse` is high in the third cycle after the cycle in which `mode_in` changed. That delay comes from two synchronizer stages plus the idle state register.
- R3: `img_sel` takes the synchronized target mode (0 = SD image, 1 = HD image) in the same cycle `load_pulse` rises. It stays unchanged until the sequence ends.
- R4: `load_pulse` is high for exactly one cycle per sequence.
- R5: After the load strobe, the block waits for `eng_busy` to go high and then low. `apply_pulse` is high SETTLE_CYC+1 cycles after the first cycle in which `eng_busy` is low again. It never rises while the load phase is incomplete.
- R6: `apply_pulse` is high for exactly one cycle per sequence, and only after the load phase.
- R7: After the apply strobe, the block waits for `eng_busy` to rise and fall. The lock window is the LOCK_TMO clock edges that follow the edge at which `eng_busy` is sampled low. If `pll_locked` is sampled high at any of those edges, `seq_done` is high for exactly one cycle, in the cycle after that edge. Lock seen while busy is still high does not end the sequence.
- R8: If `pll_locked` is not sampled high within that window, `seq_err` goes high in the cycle after the last edge of the window and no done pulse is given. The error stays high until the next sequence's load strobe, at which point it is cleared.
- R9: A mode change that arrives mid-sequence is not lost. Its own load strobe follows two cycles after the done cycle.
- R10: No sequence starts while the synchronized mode equals the programmed image. This includes a mid-sequence change that reverts before the sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running housekeeping clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_in | input | 1 | Video standard select, 0 = SD, 1 = HD (asynchronous) |
| eng_busy | input | 1 | Reconfiguration engine busy flag |
| pll_locked | input | 1 | Synthesizer lock indication |
| load_pulse | output | 1 | One-cycle load-from-memory command |
| apply_pulse | output | 1 | One-cycle reconfigure/apply command |
| img_sel | output | 1 | Parameter image select, 0 = SD, 1 = HD |
| seq_done | output | 1 | One-cycle successful completion pulse |
| seq_err | output | 1 | Sticky lock-timeout error |

## Verification
The bench builds the block with SETTLE_CYC = 3 and LOCK_TMO = 16. A settle delay above the default makes the exact apply-strobe timing distinguishable from a fixed one-cycle wait. The short lock window lets the bench hit both edges of it in a few dozen cycles: lock on the last permitted edge succeeds, and lock absent for the whole window produces the error. Mid-sequence mode changes, both latched and reverted, as well as a reset during the load phase, are driven at fixed cycle offsets against a hand-driven busy flag.

// File: rtl/clk_reprog_pkg.sv
package clk_reprog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LD_WAIT_HI,
        ST_LD_WAIT_LO,
        ST_SETTLE,
        ST_APPLY,
        ST_AP_WAIT_HI,
        ST_AP_WAIT_LO,
        ST_LOCK_WAIT,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/reprog_mode_sync.sv
module reprog_mode_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/reprog_timer.sv
module reprog_timer #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [WIDTH-1:0] ld_val,
    input  logic             en,
    output logic             zero
);
    logic [WIDTH-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (en && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/reprog_fsm.sv
module reprog_fsm
    import clk_reprog_pkg::*;
#(
    parameter int SETTLE_CYC = 1,
    parameter int LOCK_TMO   = 1024,
    parameter int TW         = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_s,
    input  logic          eng_busy,
    input  logic          pll_locked,
    input  logic          tmr_zero,
    output logic          tmr_ld,
    output logic [TW-1:0] tmr_val,
    output logic          tmr_en,
    output logic          load_pulse,
    output logic          apply_pulse,
    output logic          img_sel,
    output logic          seq_done,
    output logic          seq_err
);
    localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] LOCK_LD   = TW'(LOCK_TMO - 1);

    seq_state_t state, nxt;
    logic       img_q;
    logic       err_q;
    logic       timeout;

    assign timeout = (state == ST_LOCK_WAIT) && !pll_locked && tmr_zero;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:       if (mode_s != img_q) nxt = ST_LOAD;
            ST_LOAD:       nxt = ST_LD_WAIT_HI;
            ST_LD_WAIT_HI: if (eng_busy) nxt = ST_LD_WAIT_LO;
            ST_LD_WAIT_LO: if (!eng_busy) nxt = ST_SETTLE;
            ST_SETTLE:     if (tmr_zero) nxt = ST_APPLY;
            ST_APPLY:      nxt = ST_AP_WAIT_HI;
            ST_AP_WAIT_HI: if (eng_busy) nxt = ST_AP_WAIT_LO;
            ST_AP_WAIT_LO: if (!eng_busy) nxt = ST_LOCK_WAIT;
            ST_LOCK_WAIT: begin
                if (pll_locked) nxt = ST_DONE;
                else if (tmr_zero) nxt = ST_IDLE;
            end
            ST_DONE:       nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    // state register, image select and error flag
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            img_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && nxt == ST_LOAD) begin
                img_q <= mode_s;
                err_q <= 1'b0;
            end else if (timeout) begin
                err_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        load_pulse  = (state == ST_LOAD);
        apply_pulse = (state == ST_APPLY);
        seq_done    = (state == ST_DONE);
        tmr_en      = (state == ST_SETTLE) || (state == ST_LOCK_WAIT);
        tmr_ld      = 1'b0;
        tmr_val     = SETTLE_LD;
        if (state == ST_LD_WAIT_LO && !eng_busy) begin
            tmr_ld  = 1'b1;
            tmr_val = SETTLE_LD;
        end else if (state == ST_AP_WAIT_LO && !eng_busy) begin
            tmr_ld  = 1'b1;
            tmr_val = LOCK_LD;
        end
    end

    assign img_sel = img_q;
    assign seq_err = err_q;

    // R1: reset leaves every strobe and flag low
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!load_pulse && !apply_pulse && !seq_done && !seq_err && !img_sel));

    // R3: image select frozen while a sequence runs
    a_r3_img_stable: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(img_sel));

    // R4: load strobe lasts one cycle
    a_r4_load_single: assert property (@(posedge clk) disable iff (rst)
        load_pulse |=> !load_pulse);

    // R6: apply strobe lasts one cycle
    a_r6_apply_single: assert property (@(posedge clk) disable iff (rst)
        apply_pulse |=> !apply_pulse);

    // R7: done pulse lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !seq_done);

    // R8: the error is never raised together with done
    a_r8_err_not_done: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_err) |-> !seq_done);

endmodule

// File: rtl/clk_reprog_seq.sv
module clk_reprog_seq #(
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE_CYC  = 1,
    parameter int LOCK_TMO    = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_in,
    input  logic eng_busy,
    input  logic pll_locked,
    output logic load_pulse,
    output logic apply_pulse,
    output logic img_sel,
    output logic seq_done,
    output logic seq_err
);
    localparam int TMR_MAX = (SETTLE_CYC > LOCK_TMO) ? SETTLE_CYC : LOCK_TMO;
    localparam int TW      = $clog2(TMR_MAX + 1);

    logic          mode_s;
    logic          tmr_ld;
    logic [TW-1:0] tmr_val;
    logic          tmr_en;
    logic          tmr_zero;

    reprog_mode_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (mode_in),
        .dout (mode_s)
    );

    reprog_timer #(.WIDTH(TW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .ld     (tmr_ld),
        .ld_val (tmr_val),
        .en     (tmr_en),
        .zero   (tmr_zero)
    );

    reprog_fsm #(
        .SETTLE_CYC (SETTLE_CYC),
        .LOCK_TMO   (LOCK_TMO),
        .TW         (TW)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .mode_s      (mode_s),
        .eng_busy    (eng_busy),
        .pll_locked  (pll_locked),
        .tmr_zero    (tmr_zero),
        .tmr_ld      (tmr_ld),
        .tmr_val     (tmr_val),
        .tmr_en      (tmr_en),
        .load_pulse  (load_pulse),
        .apply_pulse (apply_pulse),
        .img_sel     (img_sel),
        .seq_done    (seq_done),
        .seq_err     (seq_err)
    );

endmodule

// File: tb/clk_reprog_seq_test.sv
module clk_reprog_seq_test;
    localparam int SET = 3;
    localparam int TMO = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_in = 1'b0;
    logic busy = 1'b0;
    logic locked = 1'b1;
    logic load_pulse, apply_pulse, img_sel, seq_done, seq_err;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;

    always #4 clk = ~clk;

    clk_reprog_seq #(.SYNC_STAGES(2), .SETTLE_CYC(SET), .LOCK_TMO(TMO)) uut (
        .clk (clk), .rst (rst), .mode_in (mode_in), .eng_busy (busy),
        .pll_locked (locked), .load_pulse (load_pulse), .apply_pulse (apply_pulse),
        .img_sel (img_sel), .seq_done (seq_done), .seq_err (seq_err)
    );

    always @(negedge clk) if (!rst && seq_done) done_cnt++;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // drive a mode change and check the load strobe timing
    task automatic start_seq(logic target);
        @(negedge clk) mode_in = target;
        step(2);
        chk("R2 load early", load_pulse, 0);
        step(1);
        chk("R2 load on third cycle", load_pulse, 1);
        chk("R3 img_sel at load", img_sel, target);
        chk("R8 err cleared at load", seq_err, 0);
    endtask

    // from the load cycle to the apply cycle
    task automatic load_phase(int rise_delay, logic exp_img);
        step(1);
        chk("R4 load single", load_pulse, 0);
        for (int i = 0; i < rise_delay; i++) begin
            step(1);
            chk("R5 no apply before busy rises", apply_pulse, 0);
        end
        busy = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step(1);
            chk("R5 no apply while busy", apply_pulse, 0);
            chk("R3 img stable", img_sel, exp_img);
        end
        busy = 1'b0;
        for (int i = 0; i < SET; i++) begin
            step(1);
            chk("R5 settle wait", apply_pulse, 0);
        end
        step(1);
        chk("R5 apply after settle", apply_pulse, 1);
        chk("R3 img stable at apply", img_sel, exp_img);
    endtask

    // from the apply cycle to the end; lock_at > TMO means lock never returns
    task automatic apply_phase(int lock_at, logic early_lock);
        int d0;
        d0 = done_cnt;
        step(1);
        chk("R6 apply single", apply_pulse, 0);
        locked = early_lock;
        busy = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step(1);
            chk("R7 no done while busy", seq_done, 0);
        end
        busy = 1'b0;
        if (early_lock) begin
            step(1);
            chk("R7 early lock done wait", seq_done, 0);
            step(1);
            chk("R7 early lock done", seq_done, 1);
            step(1);
            chk("R7 done single", seq_done, 0);
        end else if (lock_at <= TMO) begin
            for (int i = 0; i < lock_at; i++) begin
                step(1);
                chk("R7 no done before lock", seq_done, 0);
            end
            locked = 1'b1;
            step(1);
            chk("R7 done after lock", seq_done, 1);
            step(1);
            chk("R7 done single", seq_done, 0);
            chk("R7 done count", done_cnt - d0, 1);
        end else begin
            for (int i = 0; i < TMO; i++) begin
                step(1);
                chk("R8 no err inside window", seq_err, 0);
            end
            step(1);
            chk("R8 err after window", seq_err, 1);
            chk("R8 no done on timeout", done_cnt - d0, 0);
            locked = 1'b1;
        end
    endtask

    task automatic no_start(int n, string tag);
        for (int i = 0; i < n; i++) begin
            step(1);
            chk(tag, load_pulse, 0);
        end
    endtask

    task automatic t_reset();
        step(4);
        chk("R1 load in reset", load_pulse, 0);
        chk("R1 apply in reset", apply_pulse, 0);
        chk("R1 done in reset", seq_done, 0);
        chk("R1 err in reset", seq_err, 0);
        chk("R1 img in reset", img_sel, 0);
        rst = 1'b0;
    endtask

    task automatic t_latched();
        start_seq(1'b0);
        mode_in = 1'b1;
        load_phase(0, 1'b0);
        apply_phase(2, 1'b0);
        step(1);
        chk("R9 latched request starts", load_pulse, 1);
        chk("R9 latched image", img_sel, 1);
        load_phase(0, 1'b1);
        apply_phase(1, 1'b0);
    endtask

    task automatic t_revert();
        start_seq(1'b0);
        mode_in = 1'b1;
        load_phase(1, 1'b0);
        mode_in = 1'b0;
        apply_phase(2, 1'b0);
        no_start(10, "R10 reverted change ignored");
    endtask

    task automatic t_reset_mid();
        start_seq(1'b1);
        step(1);
        busy = 1'b1;
        step(2);
        rst = 1'b1;
        step(1);
        chk("R1 reset mid img", img_sel, 0);
        chk("R1 reset mid apply", apply_pulse, 0);
        chk("R1 reset mid load", load_pulse, 0);
        mode_in = 1'b0;
        busy = 1'b0;
        step(2);
        rst = 1'b0;
        no_start(8, "R1 idle after reset");
    endtask

    initial begin
        t_reset();
        no_start(10, "R10 idle without change");
        start_seq(1'b1);
        load_phase(0, 1'b1);
        apply_phase(1, 1'b0);
        start_seq(1'b0);
        load_phase(2, 1'b0);
        apply_phase(TMO, 1'b0);
        start_seq(1'b1);
        load_phase(0, 1'b1);
        apply_phase(0, 1'b1);
        start_seq(1'b0);
        load_phase(0, 1'b0);
        apply_phase(TMO + 1, 1'b0);
        for (int i = 0; i < 6; i++) begin
            step(1);
            chk("R8 err held", seq_err, 1);
            chk("R10 no restart after err", load_pulse, 0);
        end
        start_seq(1'b1);
        load_phase(0, 1'b1);
        apply_phase(3, 1'b0);
        chk("R8 err stays clear", seq_err, 0);
        t_latched();
        t_revert();
        t_reset_mid();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule